// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block sits beside a CPU core and decides which of six latched interrupt request flags is taken. Each source has its own enable bit and a two-bit priority level. The two bits come from a high and a low priority register at the same bit position, and the high bit is the MSB. A global enable gates everything. When the CPU raises an instruction-boundary strobe, the block picks the winning request. In the following cycle it pulses a take strobe together with the winner's vector address.

The block keeps one in-service bit per priority level, and these bits enforce nesting. A running handler is preempted only by a strictly higher level. A return strobe from the CPU releases the highest level in service. A separate combinational wakeup output tells the power controller when an enabled request from a wake-capable source is present during power-down.

Request flag bits on `flag_i` are ordered by polling rank. The brownout source has the best rank.

| Bit | Source | Rank | Vector |
|-----|--------|------|--------|
| 0 | brownout | 1 | 0x002B |
| 1 | watchdog/RTC | 2 | 0x0053 |
| 2 | timer 0 | 3 | 0x000B |
| 3 | keyboard | 4 | 0x003B |
| 4 | timer 1 | 5 | 0x001B |
| 5 | comparator | 6 | 0x0043 |

Top module: `irq_prio_ctrl`

## Requirements
- R1: A source's level is {high bit, low bit}, taken from the high and low priority inputs of its register pair at the source's bit position. Level 3 is the highest and level 0 the lowest.
- R2: The enable and priority bit positions are as follows. In register set 0: timer 0 uses bit 1, timer 1 bit 3, brownout bit 5 and watchdog/RTC bit 6. In register set 1: keyboard uses bit 1 and comparator bit 2. A source whose enable bit is 0 is never taken.
- R3: Bit 7 of `en0_i` is the global enable. While it is 0 at a boundary sample, no interrupt is taken.
- R4: Arbitration uses the inputs only at a clock edge where `boundary_i` is 1. `take_o` is then 1 for exactly the following cycle. `vector_o` changes only at a take and holds its value otherwise.
- R5: Among eligible requests (flag and enable both 1), one of the highest level wins.
- R6: Among eligible requests of the winning level, the one with the lowest flag bit index wins (polling rank 1 to 6).
- R7: `vector_o` on a take is 0x002B, 0x0053, 0x000B, 0x003B, 0x001B or 0x0043 for flag bits 0 to 5 respectively.
- R8: A take occurs only if no level is in service, or if the winner's level is strictly above the running level. While level 3 runs, nothing is taken.
- R9: A take sets `in_service_o[level]` of the winner. `run_active_o` is 1 when any in-service bit is set, and `run_level_o` is the index of the highest set bit.
- R10: `reti_i` at an edge clears the highest set in-service bit. If a take happens at the same edge, preemption is judged against the level before the return, and both updates apply.
- R11: `wake_o` is `pdown_i` AND global enable AND the OR of (flag AND enable) over brownout, watchdog/RTC, keyboard and comparator. Timer flags never raise it. It is combinational.
- R12: In reset, `take_o`, `vector_o`, `in_service_o`, `run_active_o` and `run_level_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flag_i | input | 6 | Latched request flags, rank order |
| en0_i | input | 8 | Enable register set 0, bit 7 global enable |
| en1_i | input | 8 | Enable register set 1 |
| pri0_hi_i | input | 8 | Priority high bits, set 0 |
| pri0_lo_i | input | 8 | Priority low bits, set 0 |
| pri1_hi_i | input | 8 | Priority high bits, set 1 |
| pri1_lo_i | input | 8 | Priority low bits, set 1 |
| boundary_i | input | 1 | Instruction boundary, arbitration sample |
| reti_i | input | 1 | Return from interrupt |
| pdown_i | input | 1 | CPU is in power-down |
| take_o | output | 1 | One-cycle take-interrupt strobe |
| vector_o | output | 16 | Vector of the last taken source |
| wake_o | output | 1 | Power-down wakeup request |
| in_service_o | output | 4 | In-service bit per level |
| run_active_o | output | 1 | Some level is in service |
| run_level_o | output | 2 | Highest level in service |

## Verification
A return and a new take can land on the same clock edge. The return clears the old top level while the take sets a higher one, and the preemption test must use the level from before the return. The bench provokes this directly with a running level-1 handler, then a return plus a boundary carrying a level-2 request. Random stimulus also pulses the return strobe alongside boundaries. The in-service vector after that edge is judged against a bench model that applies both updates to the pre-edge state.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NSRC     = 6;
  localparam int NLVL     = 4;
  localparam int LVL_W    = $clog2(NLVL);
  localparam int IDX_W    = $clog2(NSRC);
  localparam int VEC_W    = 16;
  localparam int REG_W    = 8;
  localparam int EA_BIT   = 7;

  // index = polling rank - 1: bo, wdt, t0, kbd, t1, cmp
  localparam logic [NSRC-1:0] IN_SET1   = 6'b101000;
  localparam logic [NSRC-1:0] WAKE_MASK = 6'b101011;

  function automatic int unsigned src_bit(input int unsigned i);
    case (i)
      0:       return 5;
      1:       return 6;
      2:       return 1;
      3:       return 1;
      4:       return 3;
      default: return 2;
    endcase
  endfunction

  function automatic logic [VEC_W-1:0] src_vector(input int unsigned i);
    case (i)
      0:       return 16'h002B;
      1:       return 16'h0053;
      2:       return 16'h000B;
      3:       return 16'h003B;
      4:       return 16'h001B;
      default: return 16'h0043;
    endcase
  endfunction
endpackage

// File: rtl/irq_src_map.sv
module irq_src_map
  import irq_prio_pkg::*;
(
  input  logic [REG_W-1:0]            en0_i,
  input  logic [REG_W-1:0]            en1_i,
  input  logic [REG_W-1:0]            pri0_hi_i,
  input  logic [REG_W-1:0]            pri0_lo_i,
  input  logic [REG_W-1:0]            pri1_hi_i,
  input  logic [REG_W-1:0]            pri1_lo_i,
  output logic [NSRC-1:0]             en_o,
  output logic [NSRC-1:0][LVL_W-1:0]  lvl_o
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    localparam int unsigned B = src_bit(g);
    if (IN_SET1[g]) begin : g_set1
      assign en_o[g]  = en1_i[B];
      assign lvl_o[g] = {pri1_hi_i[B], pri1_lo_i[B]};
    end else begin : g_set0
      assign en_o[g]  = en0_i[B];
      assign lvl_o[g] = {pri0_hi_i[B], pri0_lo_i[B]};
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_prio_pkg::*;
(
  input  logic [NSRC-1:0]             req_i,
  input  logic [NSRC-1:0][LVL_W-1:0]  lvl_i,
  output logic                        any_o,
  output logic [IDX_W-1:0]            win_idx_o,
  output logic [LVL_W-1:0]            win_lvl_o
);
  // strict compare keeps the lower index (better rank) on a tie
  always_comb begin
    any_o     = 1'b0;
    win_idx_o = '0;
    win_lvl_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req_i[i] && (!any_o || lvl_i[i] > win_lvl_o)) begin
        any_o     = 1'b1;
        win_idx_o = IDX_W'(i);
        win_lvl_o = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_isr_track.sv
module irq_isr_track
  import irq_prio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [LVL_W-1:0]  take_lvl_i,
  input  logic              ret_i,
  output logic [NLVL-1:0]   isr_o,
  output logic              active_o,
  output logic [LVL_W-1:0]  level_o
);
  logic [NLVL-1:0] isr_q, top_mask, set_mask;

  always_comb begin
    active_o = 1'b0;
    level_o  = '0;
    top_mask = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (isr_q[l]) begin
        active_o = 1'b1;
        level_o  = LVL_W'(l);
        top_mask = NLVL'(1) << l;
      end
    end
  end

  always_comb begin
    set_mask = '0;
    if (take_i) set_mask[take_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= (isr_q & ~(ret_i ? top_mask : '0)) | set_mask;
  end

  assign isr_o = isr_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NSRC-1:0]         flag_i,
  input  logic [REG_W-1:0]        en0_i,
  input  logic [REG_W-1:0]        en1_i,
  input  logic [REG_W-1:0]        pri0_hi_i,
  input  logic [REG_W-1:0]        pri0_lo_i,
  input  logic [REG_W-1:0]        pri1_hi_i,
  input  logic [REG_W-1:0]        pri1_lo_i,
  input  logic                    boundary_i,
  input  logic                    reti_i,
  input  logic                    pdown_i,
  output logic                    take_o,
  output logic [VEC_W-1:0]        vector_o,
  output logic                    wake_o,
  output logic [NLVL-1:0]         in_service_o,
  output logic                    run_active_o,
  output logic [LVL_W-1:0]        run_level_o
);
  logic [NSRC-1:0]            src_en, eligible;
  logic [NSRC-1:0][LVL_W-1:0] src_lvl;
  logic                       any_req, take_d, take_q;
  logic [IDX_W-1:0]           win_idx;
  logic [LVL_W-1:0]           win_lvl;
  logic [VEC_W-1:0]           win_vec, vec_q;
  logic                       glob_en;

  assign glob_en = en0_i[EA_BIT];

  irq_src_map u_map (
    .en0_i, .en1_i, .pri0_hi_i, .pri0_lo_i, .pri1_hi_i, .pri1_lo_i,
    .en_o (src_en),
    .lvl_o(src_lvl)
  );

  assign eligible = flag_i & src_en;

  irq_arbiter u_arb (
    .req_i    (eligible),
    .lvl_i    (src_lvl),
    .any_o    (any_req),
    .win_idx_o(win_idx),
    .win_lvl_o(win_lvl)
  );

  always_comb begin
    win_vec = '0;
    for (int i = 0; i < NSRC; i++)
      if (win_idx == IDX_W'(i)) win_vec = src_vector(i);
  end

  // preemption is judged against the level before any same-edge return
  assign take_d = boundary_i && glob_en && any_req &&
                  (!run_active_o || win_lvl > run_level_o);

  irq_isr_track u_isr (
    .clk_i,
    .rst_ni,
    .take_i    (take_d),
    .take_lvl_i(win_lvl),
    .ret_i     (reti_i),
    .isr_o     (in_service_o),
    .active_o  (run_active_o),
    .level_o   (run_level_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      take_q <= take_d;
      if (take_d) vec_q <= win_vec;
    end
  end

  assign take_o   = take_q;
  assign vector_o = vec_q;
  assign wake_o   = pdown_i && glob_en && |(eligible & WAKE_MASK);
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
  import irq_prio_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               boundary_i,
  input logic               reti_i,
  input logic               pdown_i,
  input logic [REG_W-1:0]   en0_i,
  input logic               take_o,
  input logic               wake_o,
  input logic [NLVL-1:0]    in_service_o,
  input logic               run_active_o,
  input logic [LVL_W-1:0]   run_level_o
);
  // R4
  take_after_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(boundary_i));

  // R3
  no_take_without_ea_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en0_i[EA_BIT] |=> !take_o);

  // R8
  strict_preempt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> run_active_o && (!$past(run_active_o) || run_level_o > $past(run_level_o)));

  // R8
  top_level_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_active_o && run_level_o == LVL_W'(NLVL-1)) |=> !take_o);

  // R10
  reti_drops_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !boundary_i && in_service_o != '0) |=>
      $countones(in_service_o) + 1 == $countones($past(in_service_o)));

  // R11
  wake_needs_pdown_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pdown_i |-> !wake_o);

  // R9
  active_matches_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_active_o == (in_service_o != '0));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .boundary_i  (boundary_i),
  .reti_i      (reti_i),
  .pdown_i     (pdown_i),
  .en0_i       (en0_i),
  .take_o      (take_o),
  .wake_o      (wake_o),
  .in_service_o(in_service_o),
  .run_active_o(run_active_o),
  .run_level_o (run_level_o)
);

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  flag = '0;
  logic [7:0]  en0 = '0, en1 = '0, h0 = '0, l0 = '0, h1 = '0, l1 = '0;
  logic        bnd = 1'b0, ret = 1'b0, pd = 1'b0;
  logic        take, wake, act;
  logic [15:0] vec;
  logic [3:0]  isr;
  logic [1:0]  rlvl;

  int checks = 0, errors = 0;
  logic [3:0]  m_isr = '0;
  logic [15:0] m_vec = '0;

  always #2 clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .flag_i(flag),
    .en0_i(en0), .en1_i(en1),
    .pri0_hi_i(h0), .pri0_lo_i(l0), .pri1_hi_i(h1), .pri1_lo_i(l1),
    .boundary_i(bnd), .reti_i(ret), .pdown_i(pd),
    .take_o(take), .vector_o(vec), .wake_o(wake),
    .in_service_o(isr), .run_active_o(act), .run_level_o(rlvl)
  );

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, a, e);
    end
  endtask

  // flag bit order: 0 bo, 1 wdt, 2 t0, 3 kbd, 4 t1, 5 cmp
  function automatic logic b_en(input int s);
    case (s)
      0: return en0[5];
      1: return en0[6];
      2: return en0[1];
      3: return en1[1];
      4: return en0[3];
      default: return en1[2];
    endcase
  endfunction

  function automatic logic [1:0] b_lvl(input int s);
    case (s)
      0: return {h0[5], l0[5]};
      1: return {h0[6], l0[6]};
      2: return {h0[1], l0[1]};
      3: return {h1[1], l1[1]};
      4: return {h0[3], l0[3]};
      default: return {h1[2], l1[2]};
    endcase
  endfunction

  function automatic logic [15:0] b_vec(input int s);
    case (s)
      0: return 16'h002B;
      1: return 16'h0053;
      2: return 16'h000B;
      3: return 16'h003B;
      4: return 16'h001B;
      default: return 16'h0043;
    endcase
  endfunction

  function automatic int top_bit(input logic [3:0] v);
    int t = -1;
    for (int l = 0; l < 4; l++) if (v[l]) t = l;
    return t;
  endfunction

  task automatic cyc(input string tag, input logic [5:0] f, input logic [7:0] e0, input logic [7:0] e1,
                     input logic [7:0] ph0, input logic [7:0] pl0, input logic [7:0] ph1,
                     input logic [7:0] pl1, input logic b, input logic r, input logic p);
    int best = -1;
    logic exp_take, exp_wake;
    int run;
    @(negedge clk);
    flag = f; en0 = e0; en1 = e1; h0 = ph0; l0 = pl0; h1 = ph1; l1 = pl1;
    bnd = b; ret = r; pd = p;
    #1;
    // R11
    exp_wake = p && e0[7] && ((f[0] && b_en(0)) || (f[1] && b_en(1)) ||
                              (f[3] && b_en(3)) || (f[5] && b_en(5)));
    chk({tag, " R11 wake"}, 32'(wake), 32'(exp_wake));
    for (int s = 0; s < 6; s++)
      if (f[s] && b_en(s) && (best < 0 || b_lvl(s) > b_lvl(best))) best = s;
    run = top_bit(m_isr);
    exp_take = b && e0[7] && best >= 0 && (run < 0 || int'(b_lvl(best)) > run);
    if (r && run >= 0) m_isr[run] = 1'b0;
    if (exp_take) begin
      m_isr[b_lvl(best)] = 1'b1;
      m_vec = b_vec(best);
    end
    @(posedge clk); #1;
    chk({tag, " R4/R8 take"}, 32'(take), 32'(exp_take));
    chk({tag, " R7 vector"}, 32'(vec), 32'(m_vec));
    chk({tag, " R9/R10 in_service"}, 32'(isr), 32'(m_isr));
    chk({tag, " R9 run_active"}, 32'(act), 32'(m_isr != 0));
    chk({tag, " R9 run_level"}, 32'(rlvl), 32'(top_bit(m_isr) < 0 ? 0 : top_bit(m_isr)));
  endtask

  task automatic drain();
    for (int k = 0; k < 4; k++) cyc("drain", 6'h0, 8'h80, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 1'b0, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #1;
    // R12 reset state
    chk("R12 take", 32'(take), 0);
    chk("R12 vector", 32'(vec), 0);
    chk("R12 in_service", 32'(isr), 0);
    chk("R12 run_level", 32'(rlvl), 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R6 tie at level 0: brownout wins
    cyc("R6 tie", 6'h3F, 8'hFF, 8'hFF, 8'h0, 8'h0, 8'h0, 8'h0, 1'b1, 1'b0, 1'b0);
    chk("R6 literal vector", 32'(vec), 32'h002B);
    drain();
    // R5/R1 timer1 at level 3 beats brownout at level 0
    cyc("R5 R1 level", 6'h11, 8'hFF, 8'hFF, 8'h08, 8'h08, 8'h0, 8'h0, 1'b1, 1'b0, 1'b0);
    chk("R5 literal vector", 32'(vec), 32'h001B);
    // R8 level 3 running, brownout at level 2 must wait
    cyc("R8 locked", 6'h01, 8'hFF, 8'hFF, 8'h20, 8'h00, 8'h0, 8'h0, 1'b1, 1'b0, 1'b0);
    drain();
    // R3 global enable clear
    cyc("R3 ea off", 6'h3F, 8'h7F, 8'hFF, 8'h0, 8'h0, 8'h0, 8'h0, 1'b1, 1'b0, 1'b1);
    // R2 timer0 flag with its enable clear
    cyc("R2 masked", 6'h04, 8'hFD, 8'hFF, 8'h0, 8'h0, 8'h0, 8'h0, 1'b1, 1'b0, 1'b0);
    // R4 no boundary
    cyc("R4 no boundary", 6'h3F, 8'hFF, 8'hFF, 8'h0, 8'h0, 8'h0, 8'h0, 1'b0, 1'b0, 1'b0);
    // R10 keyboard level 1, then return plus comparator level 2 same edge
    cyc("R10 setup", 6'h08, 8'h80, 8'h06, 8'h0, 8'h0, 8'h00, 8'h02, 1'b1, 1'b0, 1'b0);
    cyc("R10 same edge", 6'h20, 8'h80, 8'h06, 8'h0, 8'h0, 8'h04, 8'h00, 1'b1, 1'b1, 1'b0);
    chk("R10 literal in_service", 32'(isr), 32'h4);
    drain();
    // R11 timers cannot wake, keyboard can
    cyc("R11 timers", 6'h14, 8'hFF, 8'hFF, 8'h0, 8'h0, 8'h0, 8'h0, 1'b0, 1'b0, 1'b1);
    cyc("R11 kbd", 6'h08, 8'hFF, 8'hFF, 8'h0, 8'h0, 8'h0, 8'h0, 1'b0, 1'b0, 1'b1);
    drain();

    for (int n = 0; n < 3000; n++) begin
      logic [7:0] e0r;
      e0r = 8'($urandom);
      e0r[7] = ($urandom % 4) != 0;
      cyc("random", 6'($urandom), e0r, 8'($urandom), 8'($urandom), 8'($urandom),
          8'($urandom), 8'($urandom), 1'($urandom), ($urandom % 5) == 0, 1'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule